// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes one received frame at a time from a byte stream and places it in host memory through a single-outstanding memory-master port. When a frame is waiting at its input, it fetches the receive descriptor at the current ring position. The descriptor is two 32-bit words. The first word is the buffer address. The second word holds a 16-bit length field in bits 15:0 and a 16-bit flags field in bits 31:16.

If the descriptor's available flag is set, the frame bytes are stored into the buffer and the second word is written back with the stored length and a completion flag pattern. The block then pulses a receive interrupt-status output and steps the ring position, wrapping after the last descriptor. If the descriptor is not available, the frame is held at the input, not consumed, and a not-ready output is raised. The frame goes in once the host makes the descriptor available.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `mem_req_o`, `irq_rx_o`, `trunc_err_o`, `not_ready_o` and `rx_ready_o` are low, and `next_desc_addr_o` equals `ring_base_i` (index 0).
- R2: With a frame waiting, the block reads the word at `next_desc_addr_o` (buffer address), then the word at `next_desc_addr_o`+4 (length in bits 15:0, flags in bits 31:16), both with all four byte enables set.
- R3: A frame is accepted only when flags bit 15 (word bit 31) is set. Otherwise `not_ready_o` goes high, `rx_ready_o` stays low, no buffer write is made, the ring index is unchanged, and the descriptor is fetched again. `not_ready_o` clears when a descriptor is accepted.
- R4: Byte i of the frame is written, in order, as one write to word address (buffer+i) with bits 1:0 cleared. The single byte enable bit (buffer+i)[1:0] is set, and the byte is placed in that lane.
- R5: The buffer holds length+1 bytes. Bytes beyond that are consumed but not written, and `trunc_err_o` pulses together with `irq_rx_o` for that frame. A frame of exactly length+1 bytes raises no error.
- R6: After the last byte, the word at descriptor+4 is written with all byte enables: bits 15:0 hold the stored byte count, and bits 31:16 hold 0x0011 (flag bits 4 and 0 set, available flag clear).
- R7: `irq_rx_o` is high for exactly one cycle, the cycle after the write-back is acknowledged. `next_desc_addr_o` becomes `ring_base_i` + 8 × (index+1) in the cycle after that.
- R8: When the index equals `ring_last_i` (or is above it), the next index is 0.
- R9: A memory request stays asserted with stable address, direction, byte enables and data until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | 32 | Address of descriptor 0 |
| ring_last_i | input | 8 | Index of the last descriptor in the ring |
| next_desc_addr_o | output | 32 | Address of the current descriptor |
| irq_rx_o | output | 1 | One-cycle pulse that sets the receive status bit |
| trunc_err_o | output | 1 | Pulse with `irq_rx_o` when the frame was cut short |
| not_ready_o | output | 1 | High while the waiting frame is refused |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Marks the final byte of the frame |
| rx_ready_o | output | 1 | Byte accepted on a clock edge with `rx_valid_i` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes on this clock edge |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |

## Verification
Every memory access is due on the first cycle of `mem_req_o` following the previous acknowledge. The bench compares each one, in order, with a queue predicted from the descriptor and frame contents, and inserts wait states on some frames. `irq_rx_o` and `trunc_err_o` are due exactly one cycle after the write-back acknowledge, and the new descriptor address one cycle later. A per-clock model checks both outputs on every cycle, including the cycles where they must stay low. For the refused frame, the bench waits twenty cycles and checks the not-ready flag, the ready output, the buffer contents and the ring address through the ports. It then makes the descriptor available and checks the stored result.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_BUF,
      ST_RD_CTL,
      ST_STREAM,
      ST_WR_BYTE,
      ST_WB,
      ST_DONE
   } rxr_state_e;

   // flag positions inside the 16-bit flags field
   localparam int AVAIL_BIT = 15;
   localparam logic [15:0] DONE_FLAGS = 16'h0011;
   localparam int DESC_SHIFT = 3;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 8,
   parameter int DESC_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  last_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] desc_addr_o
);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (adv_i)
         idx_q <= (idx_q >= last_i) ? '0 : idx_q + 1'b1;
   end

   assign desc_addr_o = base_i + (ADDR_W'(idx_q) << DESC_SHIFT);

   // R8: leaving the last slot returns to slot 0
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && idx_q >= last_i) |=> (idx_q == '0));

   // R7: an advance moves exactly one slot forward or wraps
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> ((idx_q == '0) || (idx_q == $past(idx_q) + 1'b1)));

endmodule

// File: rtl/rxr_cap_track.sv
module rxr_cap_track #(
   parameter int LEN_W = 16,
   localparam int CNT_W = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_field_i,
   input  logic             take_i,
   input  logic             drop_i,
   output logic [CNT_W-1:0] count_o,
   output logic             room_o,
   output logic             trunc_o
);

   logic [CNT_W-1:0] cap_q;
   logic [CNT_W-1:0] cnt_q;
   logic             trunc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q   <= '0;
         cnt_q   <= '0;
         trunc_q <= 1'b0;
      end else if (load_i) begin
         cap_q   <= CNT_W'(len_field_i) + 1'b1;
         cnt_q   <= '0;
         trunc_q <= 1'b0;
      end else begin
         if (take_i) cnt_q <= cnt_q + 1'b1;
         if (drop_i) trunc_q <= 1'b1;
      end
   end

   assign count_o = cnt_q;
   assign room_o  = cnt_q < cap_q;
   assign trunc_o = trunc_q;

   // R5: a stored byte never lands beyond the buffer capacity
   p_take_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> room_o);

   // R5: bytes are dropped only once the buffer is full
   p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i |-> !room_o);

endmodule

// File: rtl/rxr_lane_mux.sv
module rxr_lane_mux #(
   parameter int MEM_W = 32,
   localparam int LANES = MEM_W / 8,
   localparam int LSB_W = $clog2(LANES)
) (
   input  logic [LSB_W-1:0] lane_i,
   input  logic [7:0]       byte_i,
   output logic [LANES-1:0] be_o,
   output logic [MEM_W-1:0] wdata_o
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign be_o[l]          = (lane_i == LSB_W'(l));
      assign wdata_o[8*l +: 8] = byte_i;
   end

   // R4: exactly one lane is enabled per byte write
   always_comb begin
      a_one_lane_r4: assert ($onehot(be_o));
   end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8,
   parameter int MEM_W  = 32,
   parameter int LEN_W  = 16,
   localparam int LANES = MEM_W / 8,
   localparam int LSB_W = $clog2(LANES),
   localparam int CNT_W = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base_i,
   input  logic [IDX_W-1:0]  ring_last_i,
   output logic [ADDR_W-1:0] next_desc_addr_o,
   output logic              irq_rx_o,
   output logic              trunc_err_o,
   output logic              not_ready_o,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   input  logic              rx_last_i,
   output logic              rx_ready_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic [MEM_W-1:0]  mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [MEM_W-1:0]  mem_rdata_i
);

   if (MEM_W != 32) begin : g_bad_mem
      $error("descriptor words are 32 bits wide");
   end
   if (ADDR_W != MEM_W) begin : g_bad_addr
      $error("buffer address must fill one descriptor word");
   end
   if (2 * LEN_W != MEM_W) begin : g_bad_len
      $error("length and flags must share one descriptor word");
   end

   rxr_state_e        state;
   logic [ADDR_W-1:0] buf_addr;
   logic [7:0]        byte_q;
   logic              last_q;
   logic              nrdy_q;

   logic [ADDR_W-1:0] desc_addr;
   logic [ADDR_W-1:0] byte_addr;
   logic [CNT_W-1:0]  count;
   logic              room, trunc;
   logic              avail, cap_load, take, drop, adv;
   logic [LANES-1:0]  lane_be;
   logic [MEM_W-1:0]  lane_data;

   assign avail    = mem_rdata_i[LEN_W + AVAIL_BIT];
   assign cap_load = (state == ST_RD_CTL) && mem_ack_i && avail;
   assign take     = (state == ST_WR_BYTE) && mem_ack_i;
   assign drop     = (state == ST_STREAM) && rx_valid_i && !room;
   assign adv      = (state == ST_DONE);
   assign byte_addr = buf_addr + ADDR_W'(count);

   rxr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DESC_SHIFT(DESC_SHIFT)) u_ptr (
      .clk(clk), .rst_n(rst_n), .base_i(ring_base_i), .last_i(ring_last_i),
      .adv_i(adv), .desc_addr_o(desc_addr)
   );

   rxr_cap_track #(.LEN_W(LEN_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .load_i(cap_load),
      .len_field_i(mem_rdata_i[LEN_W-1:0]), .take_i(take), .drop_i(drop),
      .count_o(count), .room_o(room), .trunc_o(trunc)
   );

   rxr_lane_mux #(.MEM_W(MEM_W)) u_lane (
      .lane_i(byte_addr[LSB_W-1:0]), .byte_i(byte_q),
      .be_o(lane_be), .wdata_o(lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         buf_addr <= '0;
         byte_q   <= '0;
         last_q   <= 1'b0;
         nrdy_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE:   if (rx_valid_i) state <= ST_RD_BUF;
            ST_RD_BUF: if (mem_ack_i) begin
               buf_addr <= mem_rdata_i;
               state    <= ST_RD_CTL;
            end
            ST_RD_CTL: if (mem_ack_i) begin
               nrdy_q <= !avail;
               state  <= avail ? ST_STREAM : ST_IDLE;
            end
            ST_STREAM: if (rx_valid_i) begin
               if (room) begin
                  byte_q <= rx_data_i;
                  last_q <= rx_last_i;
                  state  <= ST_WR_BYTE;
               end else if (rx_last_i) begin
                  state <= ST_WB;
               end
            end
            ST_WR_BYTE: if (mem_ack_i) state <= last_q ? ST_WB : ST_STREAM;
            ST_WB:      if (mem_ack_i) state <= ST_DONE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = desc_addr;
      mem_be_o    = '1;
      mem_wdata_o = '0;
      case (state)
         ST_RD_BUF: mem_req_o = 1'b1;
         ST_RD_CTL: begin
            mem_req_o  = 1'b1;
            mem_addr_o = desc_addr + ADDR_W'(4);
         end
         ST_WR_BYTE: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = {byte_addr[ADDR_W-1:LSB_W], LSB_W'(0)};
            mem_be_o    = lane_be;
            mem_wdata_o = lane_data;
         end
         ST_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = desc_addr + ADDR_W'(4);
            mem_wdata_o = {DONE_FLAGS, count[LEN_W-1:0]};
         end
         default: ;
      endcase
   end

   assign rx_ready_o       = (state == ST_STREAM);
   assign irq_rx_o         = (state == ST_DONE);
   assign trunc_err_o      = (state == ST_DONE) && trunc;
   assign not_ready_o      = nrdy_q;
   assign next_desc_addr_o = desc_addr;

   // R9: an unacknowledged request holds still
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_be_o) &&
                                     $stable(mem_wdata_o)));

   // R7: the interrupt pulse lasts one cycle
   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_o |=> !irq_rx_o);

   // R7: the pulse follows an acknowledged write
   p_irq_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rx_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

   // R5: the error flag only comes with the interrupt
   p_err_with_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_err_o |-> irq_rx_o);

   // R3: a refused frame is not consumed
   p_refused_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      not_ready_o |-> !rx_ready_o);

endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;

   localparam int CLK_NS = 10;
   localparam logic [31:0] BASE = 32'h0000_0040;
   localparam int LAST = 3;

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] data;
      bit          wb;
   } acc_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ring_base = BASE;
   logic [7:0]  ring_last = 8'(LAST);
   logic [31:0] next_desc_addr;
   logic        irq_rx, trunc_err, not_ready;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        rx_ready;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [0:1023];
   acc_t        exp_q[$];
   int          n_tests = 0, n_fail = 0;
   int          cyc = 0, irq_due = -10, m_idx = 0;
   bit          chk_bus = 1'b0, slow_bus = 1'b0, tog = 1'b0, exp_trunc = 1'b0;
   bit          refuse_phase = 1'b0, seen_ready = 1'b0;
   int          refuse_writes = 0;

   always #(CLK_NS/2) clk = ~clk;

   rxr_ring_writer u0 (
      .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base), .ring_last_i(ring_last),
      .next_desc_addr_o(next_desc_addr), .irq_rx_o(irq_rx), .trunc_err_o(trunc_err),
      .not_ready_o(not_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .rx_last_i(rx_last), .rx_ready_o(rx_ready), .mem_req_o(mem_req),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] be_mask(input logic [3:0] be);
      logic [31:0] m = '0;
      for (int l = 0; l < 4; l++) if (be[l]) m[8*l +: 8] = 8'hFF;
      return m;
   endfunction

   // bus responder plus per-clock reference model
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
      end else begin
         cyc++;
         mem_ack   = mem_req && (!slow_bus || tog);
         if (mem_req) tog = !tog;
         mem_rdata = mem[mem_addr[11:2]];
         if (refuse_phase) begin
            if (rx_ready) seen_ready = 1'b1;
            if (mem_req && mem_we) refuse_writes++;
         end
         if (chk_bus) begin
            if (mem_req && mem_ack) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2", "unexpected access", mem_addr, 32'h0);
               end else begin
                  acc_t e;
                  e = exp_q.pop_front();
                  chk(mem_we == e.we, e.we ? "R4" : "R2", "direction",
                      32'(mem_we), 32'(e.we));
                  chk(mem_addr == e.addr, e.wb ? "R6" : (e.we ? "R4" : "R2"),
                      "address", mem_addr, e.addr);
                  chk(mem_be == e.be, e.wb ? "R6" : (e.we ? "R4" : "R2"),
                      "byte enables", 32'(mem_be), 32'(e.be));
                  if (e.we)
                     chk((mem_wdata & be_mask(e.be)) == (e.data & be_mask(e.be)),
                         e.wb ? "R6" : "R4", "write data", mem_wdata, e.data);
                  if (e.wb) irq_due = cyc + 1;
               end
            end
            chk(irq_rx == (cyc == irq_due), "R7", "irq pulse timing",
                32'(irq_rx), 32'(cyc == irq_due));
            chk(trunc_err == (cyc == irq_due && exp_trunc), "R5", "trunc error timing",
                32'(trunc_err), 32'(cyc == irq_due && exp_trunc));
            chk(next_desc_addr == BASE + 32'(m_idx * 8), (m_idx == 0) ? "R8" : "R7",
                "descriptor address", next_desc_addr, BASE + 32'(m_idx * 8));
            if (cyc == irq_due) m_idx = (m_idx >= LAST) ? 0 : m_idx + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ack && mem_we)
         for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] = mem_wdata[8*l +: 8];
   end

   task automatic send_byte(input logic [7:0] b, input bit last);
      @(negedge clk);
      #1;
      rx_valid = 1'b1;
      rx_data  = b;
      rx_last  = last;
      while (!rx_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
   endtask

   task automatic send_frame(input int n, input int seed);
      for (int i = 0; i < n; i++) send_byte(8'((seed * 7 + i) & 8'hFF), i == n - 1);
      @(negedge clk);
      #1;
      rx_valid = 1'b0;
      rx_last  = 1'b0;
   endtask

   function automatic logic [7:0] rd_byte(input logic [31:0] a);
      return mem[a[11:2]][8*a[1:0] +: 8];
   endfunction

   task automatic run_frame(input int idx, input logic [31:0] buffer, input int lenf,
                            input int n, input int seed, input bit slow, input string req);
      logic [31:0] da;
      int cap, st;
      acc_t e;
      da  = BASE + 32'(idx * 8);
      cap = lenf + 1;
      st  = (n < cap) ? n : cap;
      mem[da[11:2]]     = buffer;
      mem[da[11:2] + 1] = {16'h8000, 16'(lenf)};
      exp_trunc = (n > cap);
      slow_bus  = slow;
      e = '{1'b0, da, 4'hF, 32'h0, 1'b0};          exp_q.push_back(e);
      e = '{1'b0, da + 4, 4'hF, 32'h0, 1'b0};      exp_q.push_back(e);
      for (int i = 0; i < st; i++) begin
         logic [31:0] a;
         a = buffer + 32'(i);
         e = '{1'b1, {a[31:2], 2'b00}, 4'(1 << a[1:0]),
               32'((seed * 7 + i) & 8'hFF) << (8 * a[1:0]), 1'b0};
         exp_q.push_back(e);
      end
      e = '{1'b1, da + 4, 4'hF, {16'h0011, 16'(st)}, 1'b1};
      exp_q.push_back(e);
      send_frame(n, seed);
      for (int w = 0; w < 2000; w++) begin
         @(negedge clk);
         #1;
         if (exp_q.size() == 0 && cyc > irq_due + 1) break;
      end
      chk(exp_q.size() == 0, req, "accesses outstanding", 32'(exp_q.size()), 32'h0);
      for (int i = 0; i < st; i++)
         chk(rd_byte(buffer + 32'(i)) == 8'((seed * 7 + i) & 8'hFF), "R4", "stored byte",
             32'(rd_byte(buffer + 32'(i))), 32'((seed * 7 + i) & 8'hFF));
      chk(rd_byte(buffer + 32'(st)) == 8'hA5, "R5", "byte past stored range",
          32'(rd_byte(buffer + 32'(st))), 32'hA5);
      chk(mem[da[11:2] + 1] == {16'h0011, 16'(st)}, "R6", "written-back word",
          mem[da[11:2] + 1], {16'h0011, 16'(st)});
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_A5A5;
      repeat (3) @(negedge clk);
      chk(!mem_req && !irq_rx && !trunc_err && !not_ready && !rx_ready, "R1",
          "outputs in reset", {27'h0, mem_req, irq_rx, trunc_err, not_ready, rx_ready}, 32'h0);
      chk(next_desc_addr == BASE, "R1", "reset address", next_desc_addr, BASE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk_bus = 1'b1;

      run_frame(0, 32'h100, 63, 5, 1, 1'b0, "R2");   // aligned buffer
      run_frame(1, 32'h203, 63, 6, 2, 1'b1, "R9");   // unaligned, wait states
      run_frame(2, 32'h300, 3, 7, 3, 1'b0, "R5");    // truncated to 4
      run_frame(3, 32'h340, 3, 4, 4, 1'b1, "R5");    // exact fit
      run_frame(0, 32'h380, 15, 9, 5, 1'b0, "R8");   // after wrap

      // R3: refused frame held until the descriptor becomes available
      chk_bus = 1'b0;
      slow_bus = 1'b0;
      mem[(BASE[11:2] + 2)]     = 32'h400;
      mem[(BASE[11:2] + 2) + 1] = {16'h0000, 16'd31};
      refuse_phase = 1'b1;
      fork
         send_frame(3, 6);
         begin
            repeat (20) @(negedge clk);
            #1;
            refuse_phase = 1'b0;
            chk(not_ready == 1'b1, "R3", "not-ready raised", 32'(not_ready), 32'h1);
            chk(!seen_ready, "R3", "ready while refused", 32'(seen_ready), 32'h0);
            chk(refuse_writes == 0, "R3", "writes while refused", 32'(refuse_writes), 32'h0);
            chk(mem[32'h400 >> 2] == 32'hA5A5_A5A5, "R3", "buffer untouched",
                mem[32'h400 >> 2], 32'hA5A5_A5A5);
            chk(next_desc_addr == BASE + 32'd8, "R3", "index held", next_desc_addr,
                BASE + 32'd8);
            mem[(BASE[11:2] + 2) + 1] = {16'h8000, 16'd31};
         end
      join
      for (int w = 0; w < 200; w++) begin
         @(negedge clk);
         #1;
         if (irq_rx) break;
      end
      chk(irq_rx == 1'b1, "R3", "frame taken after release", 32'(irq_rx), 32'h1);
      chk(not_ready == 1'b0, "R3", "not-ready cleared", 32'(not_ready), 32'h0);
      chk(mem[(BASE[11:2] + 2) + 1] == {16'h0011, 16'd3}, "R6", "released write-back",
          mem[(BASE[11:2] + 2) + 1], {16'h0011, 16'd3});
      chk(rd_byte(32'h402) == 8'((6 * 7 + 2) & 8'hFF), "R4", "released byte",
          32'(rd_byte(32'h402)), 32'((6 * 7 + 2) & 8'hFF));
      @(negedge clk);
      #1;
      chk(next_desc_addr == BASE + 32'd16, "R7", "advance after release", next_desc_addr,
          BASE + 32'd16);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule